// File: doc/BRIEF.md
# Bipolar Return-to-Zero Word Transmitter

This block takes 32-bit words from a parallel producer over a valid/ready handshake and sends each one on a unidirectional two-wire line. The line has three states. When the `line_hi` output is asserted, the line carries a one. When `line_lo` is asserted, it carries a zero. When neither is asserted, the line is at NULL. Every bit drives its level for the first half of the bit period and returns to NULL for the second half, so the receiver can recover the clock from the line.

Before a word is sent, the block can replace its top bit with an odd-parity bit. The 8-bit label field goes on the line first, most significant bit first. The remaining bits follow in ascending order. After each word the line holds NULL for a minimum gap, and no new word is accepted until that gap has ended.

The bit rate is set by a half-bit clock-enable input (`half_tick`) that the surrounding logic generates. Each pulse of `half_tick` advances the line by one half bit period. The chip-level rate generator pulses it at 25 kHz or 200 kHz to give the low rate (12.5 kbps) or the high rate (100 kbps).

Top module: `bprz_word_tx`

## Requirements
- R1: During and after reset, `line_hi` and `line_lo` are both low and `in_ready` is high.
- R2: `line_hi` and `line_lo` are never high in the same cycle.
- R3: The 32 bits are numbered 1 (LSB, `in_word[0]`) to 32 (MSB, `in_word[31]`). They go on the line in the order 8,7,6,5,4,3,2,1 and then 9,10,...,32.
- R4: While `parity_en` is high at acceptance, bit 32 is replaced by a value that makes the transmitted 32-bit word hold an odd number of ones. This includes clearing a supplied one.
- R5: While `parity_en` is low at acceptance, bit 32 is sent exactly as supplied.
- R6: Each bit drives its level for exactly one `half_tick` interval and then returns to NULL for exactly one `half_tick` interval. The first half of a word's first bit is a full interval, even when the word was accepted in the same cycle as a tick.
- R7: A one is sent on `line_hi` and a zero is sent on `line_lo`.
- R8: After the last bit of a word, the line stays NULL for at least 4 bit times, and `in_ready` stays low for the whole word and gap.
- R9: A word is taken only on a cycle where both `in_valid` and `in_ready` are high. Words presented while the block is busy have no effect on the line.
- R10: The half-bit period follows the spacing of `half_tick` pulses, so changing that spacing between words changes the bit rate with no other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Clock enable, one pulse per half bit period |
| parity_en | input | 1 | Replace bit 32 with odd parity for the word being accepted |
| in_valid | input | 1 | A word is offered |
| in_word | input | 32 | Word offered, bit 1 at index 0 |
| in_ready | output | 1 | Block is idle and will take the offered word |
| line_hi | output | 1 | Line driven to the HI level |
| line_lo | output | 1 | Line driven to the LO level |

## Verification
Two events can fall in the same cycle: a handshake acceptance and a `half_tick` pulse. The bench provokes this by raising `in_valid` in exactly the cycle where the tick is high. It then judges the result by measuring the first active half of the new word, which must still last a full tick interval. A second overlap occurs when the final gap tick lands while a producer is already holding `in_valid` high. Back-to-back words with `in_valid` held continuously provoke this case. The measured NULL run must still cover the full gap, and every word must reach the line exactly once, in the order it was offered.

// File: rtl/bprz_pkg.sv
package bprz_pkg;

    localparam int unsigned WORD_W_DEF   = 32;
    localparam int unsigned LABEL_W_DEF  = 8;
    localparam int unsigned GAP_BITS_DEF = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SEND = 2'd2,
        ST_GAP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/bprz_frame_builder.sv
module bprz_frame_builder #(
    parameter int unsigned WORD_W  = bprz_pkg::WORD_W_DEF,
    parameter int unsigned LABEL_W = bprz_pkg::LABEL_W_DEF
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              parity_en_i,
    output logic [WORD_W-1:0] serial_o
);

    logic [WORD_W-1:0] with_par;
    logic              odd_fill;

    // Top bit chosen so that the whole word has an odd count of ones.
    assign odd_fill = ~(^word_i[WORD_W-2:0]);

    always_comb begin
        with_par = word_i;
        if (parity_en_i) begin
            with_par[WORD_W-1] = odd_fill;
        end
    end

    // serial_o[k] is the k-th bit to reach the line.
    for (genvar g = 0; g < WORD_W; g++) begin : g_order
        if (g < LABEL_W) begin : g_label
            assign serial_o[g] = with_par[LABEL_W-1-g];
        end else begin : g_body
            assign serial_o[g] = with_par[g];
        end
    end

endmodule

// File: rtl/bprz_bit_sequencer.sv
module bprz_bit_sequencer #(
    parameter int unsigned WORD_W   = bprz_pkg::WORD_W_DEF,
    parameter int unsigned GAP_BITS = bprz_pkg::GAP_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              load_i,
    input  logic [WORD_W-1:0] frame_i,
    output logic              idle_o,
    output logic              active_o,
    output logic              bit_o
);
    import bprz_pkg::*;

    localparam int unsigned GAP_HALVES = 2 * GAP_BITS;
    localparam int unsigned BIT_CW     = $clog2(WORD_W);
    localparam int unsigned GAP_CW     = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(WORD_W - 1);
    localparam logic [GAP_CW-1:0] LAST_GAP = GAP_CW'(GAP_HALVES - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [WORD_W-1:0] shreg;
        logic              second_half;
        logic [BIT_CW-1:0] bit_cnt;
        logic [GAP_CW-1:0] gap_cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    s_d.shreg = frame_i;
                    s_d.state = ST_ARM;
                end
            end
            ST_ARM: begin
                // Wait for a tick so the first half is a full interval.
                if (half_tick) begin
                    s_d.state       = ST_SEND;
                    s_d.second_half = 1'b0;
                    s_d.bit_cnt     = '0;
                end
            end
            ST_SEND: begin
                if (half_tick) begin
                    if (!s_q.second_half) begin
                        s_d.second_half = 1'b1;
                    end else begin
                        s_d.second_half = 1'b0;
                        s_d.shreg       = {1'b0, s_q.shreg[WORD_W-1:1]};
                        if (s_q.bit_cnt == LAST_BIT) begin
                            s_d.state   = ST_GAP;
                            s_d.gap_cnt = '0;
                        end else begin
                            s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (half_tick) begin
                    if (s_q.gap_cnt == LAST_GAP) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.gap_cnt = s_q.gap_cnt + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state       <= ST_IDLE;
            s_q.shreg       <= '0;
            s_q.second_half <= 1'b0;
            s_q.bit_cnt     <= '0;
            s_q.gap_cnt     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_o   = (s_q.state == ST_IDLE);
    assign active_o = (s_q.state == ST_SEND) && !s_q.second_half;
    assign bit_o    = s_q.shreg[0];

endmodule

// File: rtl/bprz_line_encoder.sv
module bprz_line_encoder (
    input  logic active_i,
    input  logic bit_i,
    output logic hi_o,
    output logic lo_o
);

    always_comb begin
        hi_o = 1'b0;
        lo_o = 1'b0;
        if (active_i) begin
            hi_o = bit_i;
            lo_o = ~bit_i;
        end
    end

endmodule

// File: rtl/bprz_word_tx.sv
module bprz_word_tx #(
    parameter int unsigned WORD_W   = bprz_pkg::WORD_W_DEF,
    parameter int unsigned LABEL_W  = bprz_pkg::LABEL_W_DEF,
    parameter int unsigned GAP_BITS = bprz_pkg::GAP_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              parity_en,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              line_hi,
    output logic              line_lo
);

    logic [WORD_W-1:0] frame;
    logic              idle;
    logic              active;
    logic              cur_bit;

    bprz_frame_builder #(
        .WORD_W  (WORD_W),
        .LABEL_W (LABEL_W)
    ) u_frame (
        .word_i      (in_word),
        .parity_en_i (parity_en),
        .serial_o    (frame)
    );

    bprz_bit_sequencer #(
        .WORD_W   (WORD_W),
        .GAP_BITS (GAP_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .load_i    (in_valid && idle),
        .frame_i   (frame),
        .idle_o    (idle),
        .active_o  (active),
        .bit_o     (cur_bit)
    );

    bprz_line_encoder u_enc (
        .active_i (active),
        .bit_i    (cur_bit),
        .hi_o     (line_hi),
        .lo_o     (line_lo)
    );

    assign in_ready = idle;

endmodule

// File: rtl/bprz_word_tx_chk.sv
module bprz_word_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic half_tick,
    input logic in_valid,
    input logic in_ready,
    input logic line_hi,
    input logic line_lo
);

    a_r2_exclusive_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    // R6: the line only changes on a tick interval boundary
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(half_tick) |-> ($stable(line_hi) && $stable(line_lo)));

    // R6: an active level returns to NULL at the next tick
    a_r6_return_to_null: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_hi || line_lo) && half_tick) |=> (!line_hi && !line_lo));

    // R9: acceptance makes the block busy
    a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: ready only while the line is quiet
    a_r8_ready_when_null: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!line_hi && !line_lo));

endmodule

bind bprz_word_tx bprz_word_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .line_hi   (line_hi),
    .line_lo   (line_lo)
);

// File: tb/bprz_word_tx_bench.sv
module bprz_word_tx_bench;

    localparam int GAP_BITS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_tick = 1'b0;
    logic        parity_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        line_hi;
    logic        line_lo;

    int checks = 0;
    int errors = 0;
    int div = 8;
    int tick_cnt = 0;
    int words_sent = 0;
    int words_seen = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    bprz_word_tx u_bprz_word_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .parity_en (parity_en),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_ready  (in_ready),
        .line_hi   (line_hi),
        .line_lo   (line_lo)
    );

    // Tick generator, driven away from the active edge.
    always @(negedge clk) begin
        if (tick_cnt >= div - 1) begin
            tick_cnt  <= 0;
            half_tick <= 1'b1;
        end else begin
            tick_cnt  <= tick_cnt + 1;
            half_tick <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_serial(input logic [31:0] w, input logic pe);
        logic [31:0] x = w;
        logic [31:0] s;
        if (pe) x[31] = ~(^w[30:0]);
        for (int i = 0; i < 32; i++) s[i] = (i < 8) ? x[7-i] : x[i];
        return s;
    endfunction

    task automatic send_word(input logic [31:0] w, input string tag, input bit align);
        exp_q.push_back(expect_serial(w, parity_en));
        tag_q.push_back(tag);
        words_sent++;
        @(negedge clk);
        if (align) begin
            while (!(half_tick && in_ready)) @(negedge clk);
        end
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard
    int          run = 0;
    int          null_run = 0;
    int          bit_idx = 0;
    bit          seen_word = 1'b0;
    logic [1:0]  prev = 2'b00;
    logic [31:0] rx;

    always @(negedge clk) begin
        if (rst_n) begin
            if (line_hi && line_lo) check(1'b0, "R2", {30'd0, line_hi, line_lo}, 32'd0);
            if (line_hi || line_lo) begin
                if (prev == 2'b00) begin
                    if (bit_idx == 0) begin
                        if (seen_word)
                            check(null_run >= (1 + 2 * GAP_BITS) * div, "R8 gap",
                                  null_run, (1 + 2 * GAP_BITS) * div);
                    end else begin
                        check(null_run == div, "R6 R10 null half", null_run, div);
                    end
                    rx[bit_idx] = line_hi;
                    bit_idx++;
                    run = 1;
                    if (bit_idx == 32) begin
                        bit_idx   = 0;
                        seen_word = 1'b1;
                        words_seen++;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R9 unexpected word", rx, 32'd0);
                        end else begin
                            automatic logic [31:0] e = exp_q.pop_front();
                            automatic string t = tag_q.pop_front();
                            check(rx == e, t, rx, e);
                        end
                    end
                end else begin
                    run++;
                end
            end else begin
                if (prev != 2'b00) begin
                    check(run == div, "R6 R10 active half", run, div);
                    null_run = 1;
                end else begin
                    null_run++;
                end
            end
            prev = {line_hi, line_lo};
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", words_seen, words_sent);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!line_hi && !line_lo && in_ready, "R1 in reset",
              {29'd0, in_ready, line_hi, line_lo}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(!line_hi && !line_lo && in_ready, "R1 after reset",
              {29'd0, in_ready, line_hi, line_lo}, 32'd4);

        // R3 R7: label order and level mapping, parity off
        parity_en = 1'b0;
        send_word(32'h0000_00A5, "R3 R7 label order", 1'b1);
        send_word(32'h1234_5601, "R3 body order", 1'b0);
        send_word(32'hFFFF_FFFF, "R5 all ones kept", 1'b0);
        send_word(32'h0000_0000, "R5 zero kept", 1'b0);
        wait_idle();

        // R4: parity on, including clearing a supplied one
        parity_en = 1'b1;
        send_word(32'h0000_0000, "R4 parity set", 1'b1);
        send_word(32'h8000_0001, "R4 parity cleared", 1'b0);
        send_word(32'h7FFF_FFFF, "R4 parity on odd count", 1'b0);
        send_word(32'h4C3B_2A19, "R4 mixed word", 1'b1);
        wait_idle();

        // R9: offers while busy are ignored
        parity_en = 1'b0;
        send_word(32'hDEAD_BEEF, "R9 word before busy offers", 1'b0);
        repeat (40) @(negedge clk);
        check(!in_ready, "R8 ready low while busy", in_ready, 32'd0);
        in_valid = 1'b1;
        in_word  = 32'h5555_5555;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        check(words_seen == words_sent, "R9 busy offers dropped", words_seen, words_sent);

        // R10: faster tick spacing
        div = 4;
        repeat (10) @(negedge clk);
        send_word(32'h0F0F_0F3C, "R10 fast rate word", 1'b1);
        send_word(32'hA5A5_A5A5, "R10 fast back to back", 1'b0);
        wait_idle();
        check(words_seen == words_sent, "R9 word count", words_seen, words_sent);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule